// File: doc/BRIEF.md
# Escalation Lock Sequencer

This block steers a coprocessor through its life cycle. It starts with a secure wipe straight out of reset, then goes idle, runs on request and returns to idle when the run finishes. An escalation request arrives on a 4-bit redundant boolean input and drives the sequencer into a terminal locked state. The datapath performs the wipes. It reports completion through a one-cycle done pulse. The sequencer only requests wipes and reports its phase.

Escalation is handled asymmetrically. A valid "true" code seen while the post-reset wipe is running does not cut the wipe short. It sets a sticky lock-pending flag. When the wipe completes, the sequencer runs one final wipe and then locks. A code that is neither valid true nor valid false locks at once. Once a lock is committed, the escalation input is no longer inspected, so the path to the locked state never depends on what that input does afterwards.

Top module: `esc_lock_ctrl`

## Requirements
- R1: While `rst_ni` is low on a clock edge, all three outputs are low. The first edge with `rst_ni` high starts the post-reset wipe, and `wipe_req_o` goes high.
- R2: During the post-reset wipe, `wipe_req_o` stays high until `wipe_done_i` is sampled high. With no lock pending, the next phase is idle (`idle_o` high).
- R3: In idle, `start_i` high with escalation at valid false starts a run (all outputs low). `run_done_i` returns the block to idle. `start_i` has no effect in any other phase.
- R4: A valid true code (4'b0110) during the post-reset wipe does not end that wipe. When `wipe_done_i` arrives, a final wipe follows (`wipe_req_o` high), and the block locks when that final wipe completes.
- R5: In the reset-exit, post-reset wipe, idle and run phases with no lock committed, any code other than 4'b0110 (true) or 4'b1001 (false) moves the block to the locked state on the next edge.
- R6: Once a lock is committed (lock pending, or final wipe in progress), invalid escalation codes change nothing. Only `wipe_done_i` advances the block.
- R7: A valid true code in idle or run starts the final wipe on the next edge. The block locks after that wipe completes.
- R8: The locked state is terminal. `locking_o` stays high and the other outputs stay low whatever the inputs do, until reset.
- R9: After one cycle of valid true during the post-reset wipe, followed by arbitrary escalation codes each cycle and a wipe-done pulse every fourth cycle, `locking_o` rises within 40 cycles and `idle_o` never rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Run request, honoured only in idle |
| run_done_i | input | 1 | Run finished, returns to idle |
| esc_i | input | 4 | Escalation code (4'b0110 true, 4'b1001 false) |
| wipe_done_i | input | 1 | Datapath reports the requested wipe is complete |
| wipe_req_o | output | 1 | Wipe requested (post-reset or final wipe) |
| idle_o | output | 1 | Block is idle and can accept a start |
| locking_o | output | 1 | Terminal locked state reached |

## Verification
Every output is decoded from the state register alone. The effect of inputs driven before edge N is therefore due just after edge N, one cycle of latency, with no combinational path from any input. The driver applies inputs on the falling edge and queues the output triple it expects after the next rising edge. The monitor pops and compares that triple 2 ns after the rising edge. The randomized escalation phase has no fixed per-cycle expectation. It samples at the same point after each edge and checks only the cycle budget for reaching the locked state, plus the absence of any idle cycle.

// File: rtl/esc_lock_pkg.sv
// Shared constants and state encoding for the escalation lock sequencer.
// Assumes a 4-bit redundant boolean on the escalation input.
package esc_lock_pkg;

    localparam int MubiW = 4;
    typedef logic [MubiW-1:0] mubi4_t;

    localparam mubi4_t MuTrue  = 4'b0110;
    localparam mubi4_t MuFalse = 4'b1001;

    // Sparse state codes, pairwise Hamming distance of at least 3.
    localparam int StW = 6;
    typedef enum logic [StW-1:0] {
        StHalt     = 6'b000000,
        StWipeInit = 6'b000111,
        StIdle     = 6'b011001,
        StRun      = 6'b101010,
        StWipeLock = 6'b110100,
        StLocked   = 6'b111111
    } lk_state_e;

endpackage

// File: rtl/mubi4_classify.sv
// Classifies a redundant 4-bit boolean as valid true or invalid.
// Purely combinational. Valid false is the only remaining case.
module mubi4_classify
    import esc_lock_pkg::*;
(
    input  mubi4_t val_i,
    output logic   is_true_o,
    output logic   is_bad_o
);

    // Decode the two legal codes and flag everything else.
    always_comb begin
        is_true_o = (val_i == MuTrue);
        is_bad_o  = (val_i != MuTrue) && (val_i != MuFalse);
    end

endmodule

// File: rtl/lock_pending_reg.sv
// Sticky flag recording an accepted escalation. Cleared only by reset.
// Assumes set_i is already gated by the sequencer's sampling enable.
module lock_pending_reg (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    output logic pending_o
);

    logic pending_q;

    // Set once, hold until reset.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) pending_q <= 1'b0;
        else if (set_i) pending_q <= 1'b1;
    end

    assign pending_o = pending_q;

    a_r4_pending_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pending_q |=> pending_q);

endmodule

// File: rtl/lock_seq_fsm.sv
// Phase sequencer: reset exit, post-reset wipe, idle, run, final wipe, locked.
// Assumes esc_true_i/esc_bad_i come from a classifier of the raw input and
// pending_i from the sticky lock flag. Provides sample_en_o, which is low
// once a lock is committed, so that the escalation input is ignored from then on.
module lock_seq_fsm
    import esc_lock_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic run_done_i,
    input  logic wipe_done_i,
    input  logic esc_true_i,
    input  logic esc_bad_i,
    input  logic pending_i,
    output logic sample_en_o,
    output logic wipe_req_o,
    output logic idle_o,
    output logic locking_o
);

    lk_state_e state_q, state_d;
    logic      esc_take, esc_kill;

    // Escalation is examined only while no lock is committed.
    always_comb begin
        sample_en_o = !pending_i && (state_q != StWipeLock) && (state_q != StLocked);
        esc_take    = sample_en_o && esc_true_i;
        esc_kill    = sample_en_o && esc_bad_i;
    end

    // Next-state selection; unknown codes fall into the locked state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            StHalt: begin
                if (esc_kill) state_d = StLocked;
                else          state_d = StWipeInit;
            end
            StWipeInit: begin
                if (esc_kill)         state_d = StLocked;
                else if (wipe_done_i) state_d = (pending_i || esc_take) ? StWipeLock : StIdle;
            end
            StIdle: begin
                if (esc_kill)                   state_d = StLocked;
                else if (esc_take)              state_d = StWipeLock;
                else if (start_i && !pending_i) state_d = StRun;
            end
            StRun: begin
                if (esc_kill)        state_d = StLocked;
                else if (esc_take)   state_d = StWipeLock;
                else if (run_done_i) state_d = StIdle;
            end
            StWipeLock: begin
                if (wipe_done_i) state_d = StLocked;
            end
            StLocked: state_d = StLocked;
            default:  state_d = StLocked;
        endcase
    end

    // State register with synchronous reset to the reset-exit phase.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= StHalt;
        else         state_q <= state_d;
    end

    // Moore outputs decoded from the state register.
    always_comb begin
        wipe_req_o = (state_q == StWipeInit) || (state_q == StWipeLock);
        idle_o     = (state_q == StIdle);
        locking_o  = (state_q == StLocked);
    end

    a_r4_wipe_not_aborted: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == StWipeInit && esc_true_i && !wipe_done_i) |=> (state_q == StWipeInit));

    a_r5_bad_code_locks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sample_en_o && esc_bad_i) |=> (state_q == StLocked));

    a_r6_committed_path: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == StWipeLock) |=> (state_q == StWipeLock || state_q == StLocked));

    a_r7_escalate_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((state_q == StIdle || state_q == StRun) && sample_en_o && esc_true_i)
        |=> (state_q == StWipeLock));

    a_r3_start_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == StIdle && start_i && !pending_i && !esc_true_i && !esc_bad_i)
        |=> (state_q == StRun));

    a_r8_locked_terminal: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == StLocked) |=> (state_q == StLocked));

endmodule

// File: rtl/esc_lock_ctrl.sv
// Top of the escalation lock sequencer. Ties the code classifier, the sticky
// lock-pending flag and the phase sequencer together. Assumes the datapath
// pulses wipe_done_i while a wipe is requested.
module esc_lock_ctrl
    import esc_lock_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       start_i,
    input  logic       run_done_i,
    input  logic [3:0] esc_i,
    input  logic       wipe_done_i,
    output logic       wipe_req_o,
    output logic       idle_o,
    output logic       locking_o
);

    logic esc_true, esc_bad, pending, sample_en;

    mubi4_classify u_classify (
        .val_i     (esc_i),
        .is_true_o (esc_true),
        .is_bad_o  (esc_bad)
    );

    lock_pending_reg u_pending (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .set_i     (esc_true && sample_en),
        .pending_o (pending)
    );

    lock_seq_fsm u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .start_i     (start_i),
        .run_done_i  (run_done_i),
        .wipe_done_i (wipe_done_i),
        .esc_true_i  (esc_true),
        .esc_bad_i   (esc_bad),
        .pending_i   (pending),
        .sample_en_o (sample_en),
        .wipe_req_o  (wipe_req_o),
        .idle_o      (idle_o),
        .locking_o   (locking_o)
    );

endmodule

// File: tb/esc_lock_ctrl_test.sv
// Scoreboard bench: the driver queues the expected outputs per cycle and the
// monitor compares them 2 ns after each rising edge.
module esc_lock_ctrl_test;

    localparam logic [3:0] T = 4'b0110;
    localparam logic [3:0] F = 4'b1001;

    logic       clk = 1'b0;
    logic       rst_ni = 1'b0;
    logic       start_i = 1'b0;
    logic       run_done_i = 1'b0;
    logic [3:0] esc_i = F;
    logic       wipe_done_i = 1'b0;
    logic       wipe_req_o, idle_o, locking_o;

    typedef struct {
        logic  w;
        logic  i;
        logic  l;
        string req;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 0;

    always #4 clk = ~clk;

    esc_lock_ctrl uut (
        .clk_i       (clk),
        .rst_ni      (rst_ni),
        .start_i     (start_i),
        .run_done_i  (run_done_i),
        .esc_i       (esc_i),
        .wipe_done_i (wipe_done_i),
        .wipe_req_o  (wipe_req_o),
        .idle_o      (idle_o),
        .locking_o   (locking_o)
    );

    // Monitor: compare the oldest expectation after each rising edge.
    always @(posedge clk) begin
        exp_t x;
        #2;
        if (q.size() > 0) begin
            x = q.pop_front();
            n_cmp++;
            if ({wipe_req_o, idle_o, locking_o} !== {x.w, x.i, x.l}) begin
                n_bad++;
                $display("FAIL %s: wipe/idle/lock got %b%b%b expected %b%b%b",
                         x.req, wipe_req_o, idle_o, locking_o, x.w, x.i, x.l);
            end
        end
    end

    task automatic step(input logic rn, input logic s, input logic [3:0] e,
                        input logic wd, input logic rd,
                        input logic ew, input logic ei, input logic el,
                        input string r);
        @(negedge clk);
        rst_ni = rn; start_i = s; esc_i = e; wipe_done_i = wd; run_done_i = rd;
        q.push_back('{ew, ei, el, r});
    endtask

    // Reset for two edges, then release into the post-reset wipe (R1).
    task automatic do_reset();
        step(0, 0, F, 0, 0, 0, 0, 0, "R1");
        step(0, 0, F, 0, 0, 0, 0, 0, "R1");
        step(1, 0, F, 0, 0, 1, 0, 0, "R1");
    endtask

    task automatic drain();
        while (q.size() != 0) @(posedge clk);
        #3;
    endtask

    task automatic own_check(input bit ok, input string msg);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s", msg);
        end
    endtask

    initial begin
        // Normal flow: wipe, idle, run, back to idle; start ignored in other phases.
        do_reset();
        step(1, 0, F, 0, 0, 1, 0, 0, "R2");
        step(1, 1, F, 1, 0, 0, 1, 0, "R2");
        step(1, 0, F, 0, 0, 0, 1, 0, "R3");
        step(1, 1, F, 0, 0, 0, 0, 0, "R3");
        step(1, 1, F, 0, 0, 0, 0, 0, "R3");
        step(1, 0, F, 0, 1, 0, 1, 0, "R3");
        step(1, 0, 4'b1111, 0, 0, 0, 0, 1, "R5");
        step(1, 1, T, 1, 1, 0, 0, 1, "R8");
        step(1, 0, F, 0, 0, 0, 0, 1, "R8");
        step(1, 0, 4'b0000, 1, 0, 0, 0, 1, "R8");

        // Valid true during the post-reset wipe, then invalid codes ignored.
        do_reset();
        step(1, 0, T, 0, 0, 1, 0, 0, "R4");
        step(1, 0, 4'b0000, 0, 0, 1, 0, 0, "R6");
        step(1, 0, 4'b1010, 1, 0, 1, 0, 0, "R4");
        step(1, 1, 4'b0011, 0, 0, 1, 0, 0, "R6");
        step(1, 0, F, 1, 0, 0, 0, 1, "R4");
        step(1, 0, 4'b0101, 0, 0, 0, 0, 1, "R8");

        // True together with wipe completion goes straight to the final wipe.
        do_reset();
        step(1, 0, T, 1, 0, 1, 0, 0, "R4");
        step(1, 0, F, 1, 0, 0, 0, 1, "R4");

        // Invalid code during the uncommitted post-reset wipe.
        do_reset();
        step(1, 0, 4'b1000, 0, 0, 0, 0, 1, "R5");

        // Valid true in idle.
        do_reset();
        step(1, 0, F, 1, 0, 0, 1, 0, "R2");
        step(1, 0, T, 0, 0, 1, 0, 0, "R7");
        step(1, 0, 4'b1100, 0, 0, 1, 0, 0, "R6");
        step(1, 0, F, 1, 0, 0, 0, 1, "R7");

        // Valid true in run.
        do_reset();
        step(1, 0, F, 1, 0, 0, 1, 0, "R2");
        step(1, 1, F, 0, 0, 0, 0, 0, "R3");
        step(1, 0, T, 0, 0, 1, 0, 0, "R7");
        step(1, 0, F, 1, 0, 0, 0, 1, "R7");

        // Invalid code in run.
        do_reset();
        step(1, 0, F, 1, 0, 0, 1, 0, "R2");
        step(1, 1, F, 0, 0, 0, 0, 0, "R3");
        step(1, 0, 4'b0111, 0, 0, 0, 0, 1, "R5");
        drain();

        // Arbitrary escalation after one valid true: lock within a bound.
        for (int t = 0; t < 20; t++) begin
            bit saw_idle;
            int c;
            do_reset();
            step(1, 0, T, 0, 0, 1, 0, 0, "R4");
            drain();
            saw_idle = 0;
            c = 0;
            while (c < 40 && !locking_o) begin
                @(negedge clk);
                esc_i = 4'($urandom);
                start_i = 1'($urandom);
                run_done_i = 1'($urandom);
                wipe_done_i = (c % 4 == 3);
                @(posedge clk);
                #2;
                if (idle_o) saw_idle = 1;
                c++;
            end
            own_check(locking_o === 1'b1,
                      $sformatf("R9 trial %0d: locking got %b expected 1 after %0d cycles", t, locking_o, c));
            own_check(!saw_idle,
                      $sformatf("R9 trial %0d: idle seen got 1 expected 0", t));
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule